// File: doc/BRIEF.md
# Link Power-State Request Controller

This block owns the 4-bit interface power command field of one serial storage port. Software writes a command code into the field. The block then decides whether the command may act, given the link-layer idle status, the current interface power state, whether the port has outstanding work, and a capability bit. A legal command leads to one of two actions: a one-cycle request pulse toward the link (wake, partial or slumber), or control of the device-sleep pin. Once the command has been judged, the field reads back as zero. A zero readback tells software that a new command will be taken.

The block is built around one state machine with these states:

- `ST_IDLE` waits for a command.
- `ST_EVAL` judges the command held in the field.
- `ST_WAIT_PHY` holds an accepted device-sleep entry until PHY-ready is high.
- `ST_SLEEP` drives the device-sleep pin and accepts commands.
- `ST_EXIT_CNT` counts the exit delay down before the pin is released.
- `ST_PULSE_ACT`, `ST_PULSE_PAR` and `ST_PULSE_SLU` each emit one request pulse.

The transitions are:

- accept: `ST_IDLE`/`ST_SLEEP` → `ST_EVAL`
- reject: `ST_EVAL` → `ST_IDLE`/`ST_SLEEP`
- request: `ST_EVAL` → one of the `ST_PULSE_*` states
- enter-sleep: `ST_EVAL` → `ST_WAIT_PHY`
- phy-up: `ST_WAIT_PHY` → `ST_SLEEP`
- wake-from-sleep: `ST_EVAL` → `ST_EXIT_CNT`
- count-done: `ST_EXIT_CNT` → `ST_PULSE_ACT`
- retire: `ST_PULSE_*` → `ST_IDLE`

A device may reject a partial or slumber request. In that case its reported power state simply does not change, and the block reacts to it through the `cur_pwr` input.

Top module: `link_pwr_req_ctrl`

## Requirements
- R1: Command codes are 0h none, 1h active, 2h partial, 6h slumber and 8h device sleep. An accepted non-zero write appears on `ctrl_field` in the cycle after the write edge. The field reads 0h one cycle later. Writing 0h leaves the field at 0h and causes no action.
- R2: A write made while `link_idle` is low is ignored. The field stays 0h and no request is issued.
- R3: Reserved codes (3h–5h, 7h, 9h–Fh) are shown for one cycle, then the field returns to 0h with no request and no pin change.
- R4: Active from partial or slumber gives a pulse on `req_active`. Partial or slumber from active gives a pulse on `req_partial` or `req_slumber`. The pulse is high for exactly the cycle in which the field has returned to 0h. At most one request line is high at any time.
- R5: A request for the state the interface is already in (1h, 2h or 6h reported on `cur_pwr`, or 8h while the pin is high) causes no action.
- R6: Partial or slumber requested from a different low-power state (partial, slumber or device sleep) causes no action.
- R7: Device sleep is refused while any bit of `cmd_issued` or `active_tags` is set.
- R8: With `slp_slumber_only` set, device sleep is accepted only when `cur_pwr` is 6h. With it clear, device sleep is accepted from any state. An accepted entry raises `devslp_pin` one cycle after the field returns to 0h, provided `phy_ready` is high.
- R9: `devslp_pin` rises only on an edge at which `phy_ready` was high. An accepted entry waits for as long as `phy_ready` is low.
- R10: Active requested in device sleep loads `exit_count` = K. The pin stays high for K+1 more cycles after the field clears. The pin then falls, and `req_active` is high in the same cycle.
- R11: Writes are ignored while an entry is waiting for PHY-ready, during the exit count, and during request pulses.
- R12: After reset, `ctrl_field` is 0h, `devslp_pin` is low and all request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command field |
| cmd_wdata | input | 4 | Command code being written |
| link_idle | input | 1 | Link layer is in its idle state |
| cmd_issued | input | NSLOT | Commands issued to the port, one bit per slot |
| active_tags | input | NSLOT | Active queued tags, one bit per slot |
| cur_pwr | input | 4 | Current interface power state (1h active, 2h partial, 6h slumber) |
| slp_slumber_only | input | 1 | Device sleep may only be entered from slumber |
| phy_ready | input | 1 | PHY reports ready |
| exit_count | input | CW | Exit delay, in cycles, used when leaving device sleep |
| ctrl_field | output | 4 | Readable command field |
| req_active | output | 1 | One-cycle request to enter the active state |
| req_partial | output | 1 | One-cycle request to enter the partial state |
| req_slumber | output | 1 | One-cycle request to enter the slumber state |
| devslp_pin | output | 1 | Device-sleep signal to the device |

## Verification
The hardest situation to reach is a command that arrives while device sleep is already in force. It needs an accepted entry first: an idle port, a permitted starting state and a high PHY-ready. After that, the stimulus can try partial, slumber or a repeated sleep command, or start the timed exit and probe it with writes while it counts. The bench sweeps every code over each reported power state, with the capability bit both ways and the port both busy and quiet. Each accepted entry is then driven through a full timed exit, and directed sequences hold PHY-ready low to exercise the waiting and busy windows.

// File: rtl/lprc_pkg.sv
`timescale 1ns/1ps
package lprc_pkg;
    localparam logic [3:0] CODE_NONE    = 4'h0;
    localparam logic [3:0] CODE_ACTIVE  = 4'h1;
    localparam logic [3:0] CODE_PARTIAL = 4'h2;
    localparam logic [3:0] CODE_SLUMBER = 4'h6;
    localparam logic [3:0] CODE_DEVSLP  = 4'h8;

    typedef enum logic [2:0] {
        V_NONE,
        V_WAKE,
        V_PARTIAL,
        V_SLUMBER,
        V_SLEEP
    } verdict_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_WAIT_PHY,
        ST_SLEEP,
        ST_EXIT_CNT,
        ST_PULSE_ACT,
        ST_PULSE_PAR,
        ST_PULSE_SLU
    } fsm_e;
endpackage

// File: rtl/lprc_cmd_judge.sv
`timescale 1ns/1ps
module lprc_cmd_judge
    import lprc_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic [3:0]       code,
    input  logic [3:0]       eff_pwr,
    input  logic [NSLOT-1:0] cmd_issued,
    input  logic [NSLOT-1:0] active_tags,
    input  logic             slp_slumber_only,
    output verdict_e         verdict
);
    logic low_power;
    logic busy;

    always_comb begin
        low_power = (eff_pwr == CODE_PARTIAL) || (eff_pwr == CODE_SLUMBER) ||
                    (eff_pwr == CODE_DEVSLP);
        busy      = (|cmd_issued) || (|active_tags);
        verdict   = V_NONE;
        unique case (code)
            CODE_ACTIVE:  verdict = (eff_pwr == CODE_ACTIVE) ? V_NONE : V_WAKE;
            CODE_PARTIAL: verdict = low_power ? V_NONE : V_PARTIAL;
            CODE_SLUMBER: verdict = low_power ? V_NONE : V_SLUMBER;
            CODE_DEVSLP: begin
                if (eff_pwr == CODE_DEVSLP || busy)
                    verdict = V_NONE;
                else if (slp_slumber_only && eff_pwr != CODE_SLUMBER)
                    verdict = V_NONE;
                else
                    verdict = V_SLEEP;
            end
            default:      verdict = V_NONE;
        endcase
    end
endmodule

// File: rtl/lprc_exit_timer.sv
`timescale 1ns/1ps
module lprc_exit_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R10: the counter never wraps below zero
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done);
endmodule

// File: rtl/link_pwr_req_ctrl.sv
`timescale 1ns/1ps
module link_pwr_req_ctrl
    import lprc_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [3:0]       cmd_wdata,
    input  logic             link_idle,
    input  logic [NSLOT-1:0] cmd_issued,
    input  logic [NSLOT-1:0] active_tags,
    input  logic [3:0]       cur_pwr,
    input  logic             slp_slumber_only,
    input  logic             phy_ready,
    input  logic [CW-1:0]    exit_count,
    output logic [3:0]       ctrl_field,
    output logic             req_active,
    output logic             req_partial,
    output logic             req_slumber,
    output logic             devslp_pin
);
    fsm_e       state_q, state_d;
    logic [3:0] field_q;
    logic       slept_q;
    logic [3:0] eff_pwr;
    logic       accept;
    verdict_e   verdict;
    logic       tmr_load;
    logic       tmr_done;

    assign eff_pwr = slept_q ? CODE_DEVSLP : cur_pwr;
    assign accept  = cmd_wr && link_idle && (cmd_wdata != CODE_NONE) &&
                     (state_q == ST_IDLE || state_q == ST_SLEEP);
    assign tmr_load = (state_q == ST_EVAL) && (verdict == V_WAKE) && slept_q;

    lprc_cmd_judge #(.NSLOT(NSLOT)) judge_i (
        .code             (field_q),
        .eff_pwr          (eff_pwr),
        .cmd_issued       (cmd_issued),
        .active_tags      (active_tags),
        .slp_slumber_only (slp_slumber_only),
        .verdict          (verdict)
    );

    lprc_exit_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (exit_count),
        .run      (state_q == ST_EXIT_CNT),
        .done     (tmr_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_SLEEP: if (accept) state_d = ST_EVAL;
            ST_EVAL: begin
                unique case (verdict)
                    V_WAKE:    state_d = slept_q ? ST_EXIT_CNT : ST_PULSE_ACT;
                    V_PARTIAL: state_d = ST_PULSE_PAR;
                    V_SLUMBER: state_d = ST_PULSE_SLU;
                    V_SLEEP:   state_d = ST_WAIT_PHY;
                    default:   state_d = slept_q ? ST_SLEEP : ST_IDLE;
                endcase
            end
            ST_WAIT_PHY:  if (phy_ready) state_d = ST_SLEEP;
            ST_EXIT_CNT:  if (tmr_done) state_d = ST_PULSE_ACT;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output-side registers: command field and sleep pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= CODE_NONE;
            slept_q <= 1'b0;
        end else begin
            if (accept)
                field_q <= cmd_wdata;
            else if (state_q == ST_EVAL)
                field_q <= CODE_NONE;
            if (state_q == ST_WAIT_PHY && phy_ready)
                slept_q <= 1'b1;
            else if (state_q == ST_EXIT_CNT && tmr_done)
                slept_q <= 1'b0;
        end
    end

    assign ctrl_field  = field_q;
    assign devslp_pin  = slept_q;
    assign req_active  = (state_q == ST_PULSE_ACT);
    assign req_partial = (state_q == ST_PULSE_PAR);
    assign req_slumber = (state_q == ST_PULSE_SLU);

    // R1: a shown command clears on the following edge
    p_field_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_field != 4'h0) |=> (ctrl_field == 4'h0));
    // R2: nothing lands in the field while the link is not idle
    p_busy_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_idle && ctrl_field == 4'h0) |=> (ctrl_field == 4'h0));
    // R4: request lines are mutually exclusive
    p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_active, req_partial, req_slumber}));
    // R9: pin only rises after PHY-ready was seen
    p_pin_phy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devslp_pin) |-> $past(phy_ready));
    // R10: wake request never overlaps the pin, and release comes with it
    p_wake_after_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        devslp_pin |-> !req_active);
    p_release_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devslp_pin) |-> req_active);
endmodule

// File: tb/link_pwr_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_pwr_req_ctrl_tb_top;
    localparam int NSLOT = 32;
    localparam int CW    = 16;
    localparam int K     = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [3:0]       cmd_wdata = 4'h0;
    logic             link_idle = 1'b1;
    logic [NSLOT-1:0] cmd_issued = '0;
    logic [NSLOT-1:0] active_tags = '0;
    logic [3:0]       cur_pwr = 4'h1;
    logic             slp_slumber_only = 1'b0;
    logic             phy_ready = 1'b1;
    logic [CW-1:0]    exit_count = CW'(K);
    logic [3:0]       ctrl_field;
    logic             req_active, req_partial, req_slumber, devslp_pin;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_pwr_req_ctrl #(.NSLOT(NSLOT), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .link_idle(link_idle), .cmd_issued(cmd_issued), .active_tags(active_tags),
        .cur_pwr(cur_pwr), .slp_slumber_only(slp_slumber_only), .phy_ready(phy_ready),
        .exit_count(exit_count), .ctrl_field(ctrl_field), .req_active(req_active),
        .req_partial(req_partial), .req_slumber(req_slumber), .devslp_pin(devslp_pin)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic write(input logic [3:0] c);
        cmd_wr = 1'b1;
        cmd_wdata = c;
        tick();
        cmd_wr = 1'b0;
    endtask

    function automatic int reqs();
        return {29'd0, req_active, req_partial, req_slumber};
    endfunction

    // expected action: 0 none, 4 active, 2 partial, 1 slumber, 8 sleep
    function automatic int exp_kind(int code, int cur, bit so, bit busy);
        case (code)
            1: return (cur == 1) ? 0 : 4;
            2: return (cur == 1) ? 2 : 0;
            6: return (cur == 1) ? 1 : 0;
            8: return busy ? 0 : ((so && cur != 6) ? 0 : 8);
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int code, int cur, bit busy);
        if (code == 8) return busy ? "R7" : "R8";
        if (!(code == 1 || code == 2 || code == 6)) return "R3";
        if (code == cur) return "R5";
        if (code != 1 && cur != 1) return "R6";
        return "R4";
    endfunction

    // timed exit from device sleep with exit_count = k (R10)
    task automatic wake_exit(input int k);
        exit_count = CW'(k);
        write(4'h1);
        tick();
        for (int i = 0; i < k; i++) begin
            if (i == 0) begin
                write(4'h2); // R11: ignored during count
                chk(ctrl_field == 4'h0, "R11", ctrl_field, 0);
            end else tick();
        end
        if (k == 0) begin
            chk(devslp_pin == 1'b1, "R10", devslp_pin, 1);
        end else begin
            chk(devslp_pin == 1'b1, "R10", devslp_pin, 1);
        end
        tick();
        chk(devslp_pin == 1'b0, "R10", devslp_pin, 0);
        chk(reqs() == 4, "R10", reqs(), 4);
        tick();
        chk(reqs() == 0, "R10", reqs(), 0);
    endtask

    initial begin
        int curs[3] = '{1, 2, 6};
        repeat (3) tick();
        chk(ctrl_field == 4'h0 && devslp_pin == 1'b0 && reqs() == 0, "R12",
            {ctrl_field, devslp_pin, reqs()[2:0]}, 0);
        rst_n = 1'b1;
        tick();

        // R2: link not idle
        link_idle = 1'b0; cur_pwr = 4'h2;
        write(4'h1);
        chk(ctrl_field == 4'h0, "R2", ctrl_field, 0);
        tick();
        chk(reqs() == 0, "R2", reqs(), 0);
        link_idle = 1'b1;

        // R1: writing 0 does nothing
        write(4'h0);
        chk(ctrl_field == 4'h0, "R1", ctrl_field, 0);
        tick();
        chk(reqs() == 0, "R1", reqs(), 0);

        // sweep
        for (int code = 0; code < 16; code++)
            for (int ci = 0; ci < 3; ci++)
                for (int so = 0; so < 2; so++)
                    for (int bz = 0; bz < 2; bz++) begin
                        int kind;
                        string t;
                        cur_pwr = 4'(curs[ci]);
                        slp_slumber_only = so[0];
                        cmd_issued  = (bz == 1 && so == 0) ? NSLOT'(1) << code : '0;
                        active_tags = (bz == 1 && so == 1) ? NSLOT'(1) << (NSLOT-1) : '0;
                        kind = exp_kind(code, curs[ci], so[0], bz[0]);
                        t = tag_of(code, curs[ci], bz[0]);
                        write(4'(code));
                        chk(ctrl_field == 4'(code), "R1", ctrl_field, code);
                        tick();
                        chk(ctrl_field == 4'h0, "R1", ctrl_field, 0);
                        chk(reqs() == (kind & 7), t, reqs(), kind & 7);
                        tick();
                        if (kind == 8) begin
                            chk(devslp_pin == 1'b1, t, devslp_pin, 1);
                            cmd_issued = '0; active_tags = '0;
                            wake_exit(K);
                        end else begin
                            chk(devslp_pin == 1'b0 && reqs() == 0, t,
                                {devslp_pin, reqs()[2:0]}, 0);
                        end
                    end
        cmd_issued = '0; active_tags = '0;

        // R9: entry waits for PHY-ready
        cur_pwr = 4'h1; slp_slumber_only = 1'b0; phy_ready = 1'b0;
        write(4'h8);
        tick();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(devslp_pin == 1'b0, "R9", devslp_pin, 0);
        end
        write(4'h1); // R11: ignored while waiting
        chk(ctrl_field == 4'h0, "R11", ctrl_field, 0);
        phy_ready = 1'b1;
        tick();
        chk(devslp_pin == 1'b1, "R9", devslp_pin, 1);

        // R6: partial and slumber from device sleep ignored
        write(4'h2);
        chk(ctrl_field == 4'h2, "R6", ctrl_field, 2);
        tick();
        chk(reqs() == 0 && devslp_pin, "R6", reqs(), 0);
        write(4'h6);
        tick();
        chk(reqs() == 0 && devslp_pin, "R6", reqs(), 0);
        // R5: sleep while sleeping
        write(4'h8);
        tick(); tick();
        chk(devslp_pin == 1'b1 && reqs() == 0, "R5", devslp_pin, 1);

        // R10: zero exit count
        wake_exit(0);
        // R10: longer count
        write(4'h8); tick(); tick();
        chk(devslp_pin == 1'b1, "R8", devslp_pin, 1);
        wake_exit(6);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule